// File: doc/BRIEF.md
# Sound-Generator Bus Sequencer

This block sits between a simple host request port and a sound-generator chip that shares one bus for register addresses and data. The chip is steered by two coded control lines (a direction line and a select line) plus a third control line that is always high. The sequencer turns each host request (select a register, write data into it, or read it back) into a timed sequence on those lines. It drives the shared 8-bit bus through a separate output, an input and an output enable, so the bus pad can sit outside the block.

A host offers a request with `req_valid`, an operation code and a write value. The request is taken on a clock edge where `req_ready` is high. Setup, strobe and hold lengths come from three configuration inputs and are counted in clock cycles. For register selects and writes, the data is driven first and the control code is strobed while the data stays stable. The data is still driven for a while after the lines return to idle. For reads, the bus is released and the read code is strobed. The bus is captured at the end of the strobe and the result is handed back with a one-cycle `rsp_valid`.

Top module: `psg_bus_seq`

## Requirements
- R1: The control code is {`ctl_dir`,`ctl_sel`}: 00 idle, 01 read, 10 write data, 11 latch register number. `ctl_bc_hi` is 1 at all times.
- R2: `req_op` encodes 0 = select register (latch code), 1 = write data (write code), 2 = read (read code). Code 3 is a no-operation. It causes no bus activity and no response, and `req_ready` stays high.
- R3: After a select or write is accepted, the cycles run as follows. First come S cycles of idle code with `dq_oe`=1. Then come P cycles of the operation's code with `dq_oe`=1, then H cycles of idle code with `dq_oe`=1. In the next cycle `dq_oe`=0 and `req_ready`=1. S, P and H are `cfg_setup`, `cfg_pulse` and `cfg_hold`, and a value of 0 counts as 1.
- R4: While `dq_oe` is 1, `dq_out` equals the `req_wdata` of the accepted request and does not change.
- R5: After a read is accepted, `dq_oe` stays 0. There are P cycles of read code, then H cycles of idle code. In the next cycle `req_ready` returns to 1.
- R6: A read captures `dq_in` as present in the last read-code cycle. `rsp_valid` is 1 for exactly the cycle in which `req_ready` returns, with the value on `rsp_rdata`. `rsp_rdata` then keeps that value until the next read completes.
- R7: `req_ready` is 0 from the cycle after acceptance until the sequence ends. Requests offered while it is 0 are ignored.
- R8: During and after reset, the control code is idle, `dq_oe`=0, `req_ready`=1 and `rsp_valid`=0.
- R9: The strobe and hold lengths are those on the configuration inputs at acceptance. Later changes to those inputs do not alter a sequence in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_setup | input | CW (4) | Setup length in cycles |
| cfg_pulse | input | CW (4) | Strobe length in cycles |
| cfg_hold | input | CW (4) | Hold length in cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 2 | Operation code |
| req_wdata | input | 8 | Register number or data to write |
| rsp_valid | output | 1 | Read result valid for one cycle |
| rsp_rdata | output | 8 | Read result |
| ctl_dir | output | 1 | Direction control line |
| ctl_sel | output | 1 | Select control line |
| ctl_bc_hi | output | 1 | Third control line, held high |
| dq_out | output | 8 | Bus value to drive |
| dq_oe | output | 1 | Bus output enable |
| dq_in | input | 8 | Bus value seen on the pad |

## Verification
Every operation is tried against a cycle-by-cycle expected profile of the code lines, the enable and `req_ready`. This covers zero lengths (which must behave as one), the largest lengths and random mixes, and it separates setup, strobe and hold phases of wrong length. During reads, the bench changes `dq_in` every cycle, so that only a capture in the last strobe cycle gives the expected result. Some runs keep `req_valid` asserted with other requests while busy, or change the configuration right after acceptance. A no-operation code is also offered. These runs tell a sequencer that ignores stray inputs from one that restarts or re-times.

// File: rtl/psg_seq_pkg.sv
package psg_seq_pkg;

  typedef enum logic [1:0] {
    OP_SEL = 2'd0,
    OP_WR  = 2'd1,
    OP_RD  = 2'd2,
    OP_NOP = 2'd3
  } psg_op_e;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_SETUP = 2'd1,
    PH_PULSE = 2'd2,
    PH_HOLD  = 2'd3
  } psg_phase_e;

  localparam int BUS_W = 8;

endpackage

// File: rtl/psg_seq_rst_sync.sv
module psg_seq_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_sync = sync_q[STAGES-1];
endmodule

// File: rtl/psg_seq_timer.sv
module psg_seq_timer #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          expired
);
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load || (cnt_q != '0);
    cnt_d  = load ? load_val : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/psg_seq_ctrl.sv
module psg_seq_ctrl
  import psg_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [CW-1:0] cfg_setup,
  input  logic [CW-1:0] cfg_pulse,
  input  logic [CW-1:0] cfg_hold,
  output logic          accept,
  output logic          last_pulse,
  output logic          done,
  output psg_phase_e    phase,
  output psg_op_e       op
);
  psg_phase_e    phase_q, phase_d;
  psg_op_e       op_q, req_op_e;
  logic [CW-1:0] pulse_q, hold_q;
  logic          tmr_load, tmr_expired;
  logic [CW-1:0] tmr_val;

  // length 0 behaves as 1; counter runs from length-1 down to 0
  function automatic logic [CW-1:0] span(input logic [CW-1:0] len);
    return (len == '0) ? '0 : len - 1'b1;
  endfunction

  assign req_op_e = psg_op_e'(req_op);

  always_comb begin
    phase_d  = phase_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    accept   = (phase_q == PH_IDLE) && req_valid && (req_op_e != OP_NOP);
    case (phase_q)
      PH_IDLE: begin
        if (accept) begin
          tmr_load = 1'b1;
          if (req_op_e == OP_RD) begin
            phase_d = PH_PULSE;
            tmr_val = span(cfg_pulse);
          end else begin
            phase_d = PH_SETUP;
            tmr_val = span(cfg_setup);
          end
        end
      end
      PH_SETUP: begin
        if (tmr_expired) begin
          phase_d  = PH_PULSE;
          tmr_load = 1'b1;
          tmr_val  = span(pulse_q);
        end
      end
      PH_PULSE: begin
        if (tmr_expired) begin
          phase_d  = PH_HOLD;
          tmr_load = 1'b1;
          tmr_val  = span(hold_q);
        end
      end
      PH_HOLD: begin
        if (tmr_expired) phase_d = PH_IDLE;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      op_q    <= OP_NOP;
      pulse_q <= '0;
      hold_q  <= '0;
    end else begin
      phase_q <= phase_d;
      if (accept) begin
        op_q    <= req_op_e;
        pulse_q <= cfg_pulse;
        hold_q  <= cfg_hold;
      end
    end
  end

  psg_seq_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_expired)
  );

  assign last_pulse = (phase_q == PH_PULSE) && tmr_expired;
  assign done       = (phase_q == PH_HOLD) && tmr_expired;
  assign phase      = phase_q;
  assign op         = op_q;
endmodule

// File: rtl/psg_seq_data.sv
module psg_seq_data #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic [DW-1:0] wdata,
  input  logic          capture,
  input  logic          rd_done,
  input  logic [DW-1:0] dq_in,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata,
  output logic          rvalid
);
  logic [DW-1:0] out_q, rd_q;
  logic          rv_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      rd_q  <= '0;
      rv_q  <= 1'b0;
    end else begin
      rv_q <= rd_done;
      if (accept)  out_q <= wdata;
      if (capture) rd_q  <= dq_in;
    end
  end

  assign dq_out = out_q;
  assign rdata  = rd_q;
  assign rvalid = rv_q;
endmodule

// File: rtl/psg_bus_seq.sv
module psg_bus_seq
  import psg_seq_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CW-1:0]    cfg_setup,
  input  logic [CW-1:0]    cfg_pulse,
  input  logic [CW-1:0]    cfg_hold,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [BUS_W-1:0] req_wdata,
  output logic             rsp_valid,
  output logic [BUS_W-1:0] rsp_rdata,
  output logic             ctl_dir,
  output logic             ctl_sel,
  output logic             ctl_bc_hi,
  output logic [BUS_W-1:0] dq_out,
  output logic             dq_oe,
  input  logic [BUS_W-1:0] dq_in
);
  logic       rst_n_int;
  logic       accept, last_pulse, done;
  psg_phase_e phase;
  psg_op_e    op;

  psg_seq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_int)
  );

  psg_seq_ctrl #(.CW(CW)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n_int),
    .req_valid  (req_valid),
    .req_op     (req_op),
    .cfg_setup  (cfg_setup),
    .cfg_pulse  (cfg_pulse),
    .cfg_hold   (cfg_hold),
    .accept     (accept),
    .last_pulse (last_pulse),
    .done       (done),
    .phase      (phase),
    .op         (op)
  );

  psg_seq_data #(.DW(BUS_W)) u_data (
    .clk     (clk),
    .rst_n   (rst_n_int),
    .accept  (accept),
    .wdata   (req_wdata),
    .capture (last_pulse && (op == OP_RD)),
    .rd_done (done && (op == OP_RD)),
    .dq_in   (dq_in),
    .dq_out  (dq_out),
    .rdata   (rsp_rdata),
    .rvalid  (rsp_valid)
  );

  // code decode: select op -> 11, write -> 10, read -> 01, outside strobe -> 00
  assign ctl_dir   = (phase == PH_PULSE) && (op != OP_RD);
  assign ctl_sel   = (phase == PH_PULSE) && (op != OP_WR);
  assign ctl_bc_hi = 1'b1;
  assign dq_oe     = (phase != PH_IDLE) && (op != OP_RD);
  assign req_ready = (phase == PH_IDLE);
endmodule

// File: rtl/psg_bus_seq_chk.sv
module psg_bus_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       rsp_valid,
  input logic       ctl_dir,
  input logic       ctl_sel,
  input logic [7:0] dq_out,
  input logic       dq_oe
);
  AST_READ_BUS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctl_dir && ctl_sel) |-> !dq_oe); // R5
  AST_WRITE_DATA_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_dir |-> dq_oe); // R3
  AST_DATA_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_out)); // R4
  AST_RELEASE_AFTER_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dq_oe) |-> (!ctl_dir && !$past(ctl_dir))); // R3
  AST_BUSY_DURING_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_dir || ctl_sel) |-> !req_ready); // R7
  AST_RESULT_WITH_READY: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> req_ready); // R6
  AST_RESULT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R6
endmodule

bind psg_bus_seq psg_bus_seq_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_ready (req_ready),
  .rsp_valid (rsp_valid),
  .ctl_dir   (ctl_dir),
  .ctl_sel   (ctl_sel),
  .dq_out    (dq_out),
  .dq_oe     (dq_oe)
);

// File: tb/psg_bus_seq_bench.sv
`timescale 1ns/1ps
module psg_bus_seq_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] cfg_setup = 4'd1, cfg_pulse = 4'd1, cfg_hold = 4'd1;
  logic       req_valid = 1'b0;
  logic       req_ready;
  logic [1:0] req_op = 2'd0;
  logic [7:0] req_wdata = 8'd0;
  logic       rsp_valid;
  logic [7:0] rsp_rdata;
  logic       ctl_dir, ctl_sel, ctl_bc_hi;
  logic [7:0] dq_out;
  logic       dq_oe;
  logic [7:0] dq_in = 8'd0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  logic [7:0] last_rd = 8'd0;

  always #2 clk = ~clk;

  psg_bus_seq u_psg_bus_seq (
    .clk(clk), .rst_n(rst_n), .cfg_setup(cfg_setup), .cfg_pulse(cfg_pulse),
    .cfg_hold(cfg_hold), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .ctl_dir(ctl_dir), .ctl_sel(ctl_sel),
    .ctl_bc_hi(ctl_bc_hi), .dq_out(dq_out), .dq_oe(dq_oe), .dq_in(dq_in)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int eff(input logic [3:0] v);
    return (v == 4'd0) ? 1 : int'(v);
  endfunction

  // expected {ready, oe, dir, sel, bc_hi} at cycle i after acceptance
  function automatic logic [4:0] exp_lines(input logic [1:0] op, input int i,
                                          input int sp, input int pp, input int hp);
    int total, ps;
    logic d, s;
    bit rd;
    rd    = (op == 2'd2);
    ps    = rd ? 0 : sp;
    total = ps + pp + hp;
    d     = (op == 2'd0) || (op == 2'd1);
    s     = (op == 2'd0) || (op == 2'd2);
    if (i >= total)                return 5'b10001;
    if (i >= ps && i < ps + pp)    return {1'b0, !rd, d, s, 1'b1};
    return {1'b0, !rd, 2'b00, 1'b1};
  endfunction

  function automatic logic [7:0] pad_val(input logic [7:0] base, input int i);
    return base ^ 8'(i * 37 + 5);
  endfunction

  task automatic run_access(input logic [1:0] op, input logic [7:0] wd,
                            input logic [3:0] s, input logic [3:0] p, input logic [3:0] h,
                            input bit junk, input bit cfgchg);
    int sp, pp, hp, total;
    logic [7:0] base, exp_rd;
    bit rd;
    string tg;
    rd = (op == 2'd2);
    sp = eff(s); pp = eff(p); hp = eff(h);
    total = (rd ? 0 : sp) + pp + hp;
    base = 8'($urandom);
    exp_rd = pad_val(base, pp - 1);
    tg = cfgchg ? "R9" : (rd ? "R5" : "R3");
    @(negedge clk);
    cfg_setup = s; cfg_pulse = p; cfg_hold = h;
    req_valid = 1'b1; req_op = op; req_wdata = wd;
    @(posedge clk);
    for (int i = 0; i <= total + 1; i++) begin
      @(negedge clk);
      dq_in = pad_val(base, i);
      if (i == 0 && cfgchg) begin
        cfg_setup = 4'($urandom); cfg_pulse = 4'($urandom); cfg_hold = 4'($urandom);
      end
      if (junk && i < total - 1) begin
        req_valid = 1'b1; req_op = 2'($urandom); req_wdata = 8'($urandom);
      end else if (i == 0 || i >= total - 1) begin
        req_valid = 1'b0;
      end
      if (i <= total) begin
        chk($sformatf("%s/R1 lines op=%0d cycle=%0d", tg, op, i),
            {req_ready, dq_oe, ctl_dir, ctl_sel, ctl_bc_hi},
            exp_lines(op, i, sp, pp, hp));
        if (i < total && !rd) chk($sformatf("R4 data cycle=%0d", i), dq_out, wd);
        if (i > 0 && i < total && junk)
          chk("R7 busy while offered", req_ready, 1'b0);
      end
      if (i == total) begin
        chk("R6 result strobe", rsp_valid, rd);
        if (rd) begin
          chk("R6 captured value", rsp_rdata, exp_rd);
          last_rd = exp_rd;
        end else begin
          chk("R6 result retained", rsp_rdata, last_rd);
        end
      end
      if (i == total + 1) begin
        chk("R6 strobe one cycle", rsp_valid, 1'b0);
        chk("R7 stray request ignored", {req_ready, ctl_dir, ctl_sel, dq_oe}, 4'b1000);
      end
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk("R8 reset lines", {req_ready, dq_oe, ctl_dir, ctl_sel, rsp_valid}, 5'b10000);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R8 after reset", {req_ready, dq_oe, ctl_dir, ctl_sel, rsp_valid, ctl_bc_hi}, 6'b100001);

    // R2: no-operation code leaves the bus untouched
    req_valid = 1'b1; req_op = 2'd3; req_wdata = 8'hA5;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R2 no-op ignored", {req_ready, dq_oe, ctl_dir, ctl_sel, rsp_valid}, 5'b10000);
    end
    req_valid = 1'b0;

    // directed corners
    run_access(2'd0, 8'h07, 4'd0, 4'd0, 4'd0, 0, 0);   // R2 select, zero lengths
    run_access(2'd1, 8'h3C, 4'd15, 4'd15, 4'd15, 0, 0); // R2 write, longest
    run_access(2'd2, 8'h00, 4'd2, 4'd4, 4'd3, 0, 0);    // R2 read
    run_access(2'd2, 8'h00, 4'd0, 4'd1, 4'd0, 1, 0);    // read, stray requests
    run_access(2'd1, 8'hC3, 4'd3, 4'd2, 4'd5, 1, 0);    // write, stray requests
    run_access(2'd0, 8'h5A, 4'd2, 4'd3, 4'd2, 0, 1);    // config changed mid-run
    run_access(2'd2, 8'h00, 4'd1, 4'd6, 4'd2, 0, 1);

    for (int k = 0; k < 60; k++) begin
      logic [1:0] op;
      op = 2'($urandom_range(0, 2));
      run_access(op, 8'($urandom), 4'($urandom), 4'($urandom), 4'($urandom),
                 bit'($urandom), bit'($urandom));
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule